// File: doc/BRIEF.md
# Eight-Function Shared-Adder ALU

This block is a purely combinational arithmetic and logic unit of configurable width. It takes two operands and a three-bit function code and returns a result word, a carry out and four status flags: carry, overflow, sign and zero. All five arithmetic functions are produced by one adder. The function code chooses the adder's first input (the operand or its complement), its second input (the inverted second operand, an all-ones word or zero) and its carry-in. The two logic functions take a separate path around the adder.

The function map is deliberately irregular. Two codes give the same decrement, and two codes give the same exclusive-or. The block is meant to sit between operand registers and a result register. Flags are produced every cycle and are not stored here.

Top module: `adder_alu8`

## Requirements
- R1: With function code 0 or 2, result is opa minus 1 modulo 2^WIDTH. Carry out is 1 exactly when opa is nonzero.
- R2: With function code 1, result is opa plus the bitwise complement of opb (opa minus opb minus 1) modulo 2^WIDTH. Carry out is 1 exactly when opa > opb, comparing them as unsigned values.
- R3: With function code 3, result is the two's-complement negation of opa (2^WIDTH minus opa, modulo 2^WIDTH). Carry out is 1 exactly when opa is zero.
- R4: With function code 4, result is opa minus opb modulo 2^WIDTH. Carry out is 1 exactly when opa >= opb, comparing them as unsigned values.
- R5: Function code 5 gives the bitwise AND of opa and opb. Codes 6 and 7 both give the bitwise XOR.
- R6: For the arithmetic codes, cout and flag_c equal bit WIDTH of the adder sum, as stated in R1 to R4. For codes 5, 6 and 7 both are 0.
- R7: flag_v is 1 when the signed (two's-complement) value of the arithmetic result falls outside the range of a WIDTH-bit signed word. In adder terms, both adder inputs have the same sign and the sum's sign differs from it. flag_v is 0 for codes 5, 6 and 7.
- R8: For every code, flag_s equals result bit WIDTH-1, and flag_z is 1 exactly when all result bits are zero.
- R9: All outputs are combinational functions of the present inputs. They are valid in the same cycle, with no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| fsel | input | 3 | Function code, 0 to 7 |
| result | output | WIDTH | Function result |
| cout | output | 1 | Adder carry out |
| flag_c | output | 1 | Carry status flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_s | output | 1 | Sign flag (result MSB) |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the block at WIDTH 4 and at WIDTH 8. At both widths it sweeps every function code over every operand pair and compares each output with an arithmetic model based on signed and unsigned integer values. That sweep reaches every wrap point: the decrement of zero, negation of the most negative value, subtraction across the sign boundary and equal operands. At the narrow width, a table of hand-worked vectors also pins down exact carry and overflow values at these corners.

// File: rtl/adder_alu8.sv
module adder_alu8 #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       fsel,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             flag_c,
  output logic             flag_v,
  output logic             flag_s,
  output logic             flag_z
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] add_a, add_b;
  logic             cin;
  logic [WIDTH:0]   sum;
  logic             is_logic;
  logic [WIDTH-1:0] logic_res;

  // operand steering for the single adder
  always_comb begin
    add_a = opa;
    add_b = '0;
    cin   = 1'b0;
    case (fsel)
      3'd0, 3'd2: add_b = '1;
      3'd1:       add_b = ~opb;
      3'd3: begin
        add_a = ~opa;
        cin   = 1'b1;
      end
      3'd4: begin
        add_b = ~opb;
        cin   = 1'b1;
      end
      default: ;
    endcase
  end

  assign sum       = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, cin};
  assign is_logic  = fsel[2] & (fsel[1] | fsel[0]);
  assign logic_res = (fsel == 3'd5) ? (opa & opb) : (opa ^ opb);

  assign result = is_logic ? logic_res : sum[WIDTH-1:0];
  assign cout   = ~is_logic & sum[WIDTH];
  assign flag_c = cout;
  assign flag_v = ~is_logic & (add_a[WIDTH-1] == add_b[WIDTH-1])
                            & (sum[WIDTH-1] != add_a[WIDTH-1]);
  assign flag_s = result[WIDTH-1];
  assign flag_z = ~|result;

  always_comb begin
    if (fsel == 3'd0 || fsel == 3'd2) begin
      assert_dec_result_R1: assert (result == opa - ONE);
    end
    if (fsel == 3'd3) begin
      assert_neg_sum_R3: assert ((result + opa) == '0);
    end
    if (fsel == 3'd4) begin
      assert_sub_carry_R4: assert (cout == (opa >= opb));
    end
    if (fsel == 3'd5) begin
      assert_and_bits_R5: assert (((result & ~opa) | (~result & opa & opb)) == '0);
    end
    if (is_logic) begin
      assert_logic_no_carry_R6: assert (!cout && !flag_c);
      assert_logic_no_ovf_R7: assert (!flag_v);
    end
    assert_zero_flag_R8: assert (!(flag_z && flag_s));
  end
endmodule

// File: tb/adder_alu8_tb.sv
module adder_alu8_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] a4 = '0, b4 = '0, r4;
  logic [7:0] a8 = '0, b8 = '0, r8;
  logic [2:0] f4 = '0, f8 = '0;
  logic co4, c4, v4, s4, z4, co8, c8, v8, s8, z8;

  adder_alu8 #(.WIDTH(4)) dut_i (
    .opa(a4), .opb(b4), .fsel(f4), .result(r4), .cout(co4),
    .flag_c(c4), .flag_v(v4), .flag_s(s4), .flag_z(z4));

  adder_alu8 #(.WIDTH(8)) dut8_i (
    .opa(a8), .opb(b8), .fsel(f8), .result(r8), .cout(co8),
    .flag_c(c8), .flag_v(v8), .flag_s(s8), .flag_z(z8));

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // fsel, a, b, expected result, carry, overflow
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {3'd0, 4'b0000, 4'b0000, 4'b1111, 1'b0, 1'b0},
    {3'd2, 4'b1000, 4'b0011, 4'b0111, 1'b1, 1'b1},
    {3'd1, 4'b0101, 4'b0011, 4'b0001, 1'b1, 1'b0},
    {3'd1, 4'b0011, 4'b0011, 4'b1111, 1'b0, 1'b0},
    {3'd3, 4'b0000, 4'b0101, 4'b0000, 1'b1, 1'b0},
    {3'd3, 4'b1000, 4'b0000, 4'b1000, 1'b0, 1'b1},
    {3'd3, 4'b0011, 4'b1111, 4'b1101, 1'b0, 1'b0},
    {3'd4, 4'b0111, 4'b1000, 4'b1111, 1'b0, 1'b1},
    {3'd4, 4'b0110, 4'b0110, 4'b0000, 1'b1, 1'b0},
    {3'd5, 4'b1100, 4'b1010, 4'b1000, 1'b0, 1'b0},
    {3'd6, 4'b1100, 4'b1010, 4'b0110, 1'b0, 1'b0},
    {3'd7, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0}
  };

  function automatic string req_of(int f);
    case (f)
      0, 2:    return "R1";
      1:       return "R2";
      3:       return "R3";
      4:       return "R4";
      default: return "R5";
    endcase
  endfunction

  // returns {v, c, result[15:0]}
  function automatic logic [17:0] ref_alu(int w, int f, int a, int b);
    int half = 1 << (w - 1);
    int mask = (1 << w) - 1;
    int sa = (a >= half) ? a - (1 << w) : a;
    int sb = (b >= half) ? b - (1 << w) : b;
    int r = 0, sr = 0;
    bit c = 0, arith = 1;
    case (f)
      0, 2: begin r = a - 1; sr = sa - 1; c = (a != 0); end
      1:    begin r = a - b - 1; sr = sa - sb - 1; c = (a > b); end
      3:    begin r = -a; sr = -sa; c = (a == 0); end
      4:    begin r = a - b; sr = sa - sb; c = (a >= b); end
      5:    begin r = a & b; arith = 0; end
      default: begin r = a ^ b; arith = 0; end
    endcase
    return {arith && (sr < -half || sr > half - 1), c, 16'(r & mask)};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // hand-worked table (WIDTH 4)
    for (int i = 0; i < NV; i++) begin
      f4 = VEC[i][16:14]; a4 = VEC[i][13:10]; b4 = VEC[i][9:6];
      #1;
      check(req_of(int'(f4)), "table result", int'(r4), int'(VEC[i][5:2]));
      check("R6", "table carry", int'(co4), int'(VEC[i][1]));
      check("R6", "table flag_c", int'(c4), int'(VEC[i][1]));
      check("R7", "table overflow", int'(v4), int'(VEC[i][0]));
      check("R8", "table sign", int'(s4), int'(VEC[i][5]));
      check("R8", "table zero", int'(z4), int'(VEC[i][5:2] == 4'b0000));
    end

    // exhaustive sweep WIDTH 4, same-cycle combinational response (R9)
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          logic [17:0] e;
          f4 = 3'(f); a4 = 4'(a); b4 = 4'(b);
          #1;
          e = ref_alu(4, f, a, b);
          check(req_of(f), "w4 result", int'(r4), int'(e[3:0]));
          check("R6", "w4 carry", int'({co4, c4}), int'({e[16], e[16]}));
          check("R7", "w4 overflow", int'(v4), int'(e[17]));
          check("R8", "w4 sign/zero", int'({s4, z4}), int'({e[3], e[3:0] == 4'd0}));
        end
    @(negedge clk);

    // exhaustive sweep WIDTH 8
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          logic [17:0] e;
          f8 = 3'(f); a8 = 8'(a); b8 = 8'(b);
          #1;
          e = ref_alu(8, f, a, b);
          check(req_of(f), "w8 result", int'(r8), int'(e[7:0]));
          check("R6", "w8 carry", int'({co8, c8}), int'({e[16], e[16]}));
          check("R7", "w8 overflow", int'(v8), int'(e[17]));
          check("R8", "w8 sign/zero", int'({s8, z8}), int'({e[7], e[7:0] == 8'd0}));
        end

    done = 1;
    @(negedge clk);
    finish_run();
  end
endmodule